// File: doc/BRIEF.md
# Polyphase Interpolate-by-Four FIR Filter

This block raises the sample rate of a signed data stream by four. The eight-coefficient lowpass prototype is split into four two-coefficient phases. For each accepted sample the block emits four outputs on four back-to-back master clocks. Each output comes from the same short input history weighted by a different coefficient pair. The expanded stream with three zeros between samples is never formed. All filtering uses a single two-multiplier datapath, and a phase counter steers its coefficients.

The upstream source offers a sample with `in_valid`. The block takes it on a clock edge where `in_ready` is high, which happens only when the phase counter is at zero. The result is a stream at one quarter of the clock rate on the input side and at the full clock rate on the output side. Each output carries its phase number. The coefficients are a parameter. Prototype coefficient h[j] sits at bits [16*j+15 : 16*j] of `COEFS`. The datapath sums the products at full precision, rounds with 15 fractional bits, and saturates to 16 bits.

Top module: `polyphase_interp4`

## Requirements
- R1: A synchronous reset clears the phase counter and the two-sample history. In the cycle after reset `out_valid` is 0, `in_ready` is 1 and `out_data` is 0. The first burst after reset uses 0 as the previous sample.
- R2: `in_ready` is 1 exactly when the phase counter is 0. A sample presented with `in_valid` while `in_ready` is 0 is ignored and has no effect on any later output.
- R3: After a sample is accepted on an edge, `out_valid` is 1 for the next four cycles. In those cycles `out_phase` is 0, 1, 2, 3 in that order. A new sample can be accepted on the edge that ends the phase-3 cycle, so bursts can run without gaps.
- R4: The output for phase k (k = 0..3) is the rounded and saturated value of h[k]*x[n] + h[k+4]*x[n-1]. Here x[n] is the newest accepted sample and x[n-1] is the one before it. This equals inserting three zeros after every sample and applying the direct eight-tap filter.
- R5: Rounding adds 2^14 to the full-precision sum and then shifts it arithmetically right by 15. An exact half therefore rounds toward positive infinity.
- R6: A rounded result above 32767 is output as 32767. A rounded result below -32768 is output as -32768.
- R7: If no sample is offered in a cycle where `in_ready` is 1, `out_valid` is 0 in the next cycle. The two-sample history is held. The next burst still uses the last accepted sample as x[n-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Block can take a sample this cycle (phase counter at 0) |
| out_valid | output | 1 | `out_data` holds a new output sample |
| out_phase | output | 2 | Phase index (0..3) of the current output |
| out_data | output | 16 | Signed, rounded and saturated output sample |

## Verification
The properties assume that the source changes `in_valid` and `in_data` only between clock edges. They also assume that an offer made while `in_ready` is low is simply dropped, with no retry. Under those assumptions the valid and phase sequence can be tied directly to accept events. The stimulus follows this: inputs are driven on the falling edge. Some samples are deliberately held back for stall cycles, and while a burst is in progress the bench drives random data with `in_valid` high to show that it is discarded. The data stream includes a unit impulse, small values of both signs that land exactly on the rounding midpoint, random samples, and runs of full-scale samples of both polarities that drive the phase with the largest coefficient sum into saturation.

// File: rtl/pp_interp_pkg.sv
package pp_interp_pkg;

   // Default Q1.15 prototype; h[j] occupies bits [16*j +: 16].
   // Listed here from h[7] down to h[0].
   localparam logic [127:0] PP_DEFAULT_COEFS = {
      16'd16384, 16'd8192, 16'd16384, 16'd24576,
      16'd32767, 16'd24576, 16'd16384, 16'd8192
   };

   function automatic int unsigned pp_clog2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return (r == 0) ? 1 : r;
   endfunction

endpackage

// File: rtl/pp_delay_line.sv
module pp_delay_line #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      shift_en,
   input  logic [DATA_W-1:0]         din,
   output logic [DEPTH*DATA_W-1:0]   taps_o
);

   logic [DATA_W-1:0] hist [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      end else if (shift_en) begin
         hist[0] <= din;
         for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
      end
   end

   // On the accepting edge the phase-0 product must already see the new
   // sample, so the taps look one position ahead while shift_en is high.
   for (genvar t = 0; t < DEPTH; t++) begin : g_tap
      if (t == 0) begin : g_head
         assign taps_o[t*DATA_W +: DATA_W] = shift_en ? din : hist[0];
      end else begin : g_body
         assign taps_o[t*DATA_W +: DATA_W] = shift_en ? hist[t-1] : hist[t];
      end
   end

endmodule

// File: rtl/pp_coef_mux.sv
module pp_coef_mux #(
   parameter int COEF_W = 16,
   parameter int PHASES = 4,
   parameter int TAPS   = 2,
   parameter int PH_W   = 2,
   parameter logic [PHASES*TAPS*COEF_W-1:0] COEFS = '0
) (
   input  logic [PH_W-1:0]          sel,
   output logic [TAPS*COEF_W-1:0]   coef_o
);

   // Tap t of phase p uses prototype coefficient h[p + PHASES*t].
   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic [COEF_W-1:0] pick;
      always_comb begin
         pick = '0;
         for (int p = 0; p < PHASES; p++) begin
            if (sel == PH_W'(p)) pick = COEFS[(p + PHASES*t)*COEF_W +: COEF_W];
         end
      end
      assign coef_o[t*COEF_W +: COEF_W] = pick;
   end

endmodule

// File: rtl/pp_mac_round_sat.sv
module pp_mac_round_sat #(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int TAPS   = 2,
   parameter int FRAC_W = 15,
   parameter int OUT_W  = 16,
   parameter int ACC_W  = 34
) (
   input  logic [TAPS*DATA_W-1:0]   taps_i,
   input  logic [TAPS*COEF_W-1:0]   coefs_i,
   output logic [OUT_W-1:0]         y_o
);

   localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] scaled;

   always_comb begin
      logic signed [DATA_W-1:0] d;
      logic signed [COEF_W-1:0] c;
      acc = '0;
      for (int t = 0; t < TAPS; t++) begin
         d   = taps_i[t*DATA_W +: DATA_W];
         c   = coefs_i[t*COEF_W +: COEF_W];
         acc = acc + (ACC_W'(d) * ACC_W'(c));
      end
   end

   if (FRAC_W > 0) begin : g_round
      localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W-1);
      assign scaled = (acc + HALF) >>> FRAC_W;
   end else begin : g_plain
      assign scaled = acc;
   end

   always_comb begin
      if (scaled > SAT_HI)      y_o = SAT_HI[OUT_W-1:0];
      else if (scaled < SAT_LO) y_o = SAT_LO[OUT_W-1:0];
      else                      y_o = scaled[OUT_W-1:0];
   end

endmodule

// File: rtl/polyphase_interp4.sv
module polyphase_interp4 #(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int PHASES = 4,
   parameter int TAPS   = 2,
   parameter int FRAC_W = 15,
   parameter int OUT_W  = 16,
   parameter logic [PHASES*TAPS*COEF_W-1:0] COEFS = pp_interp_pkg::PP_DEFAULT_COEFS,
   localparam int PH_W  = pp_interp_pkg::pp_clog2(PHASES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  in_data,
   output logic               in_ready,
   output logic               out_valid,
   output logic [PH_W-1:0]    out_phase,
   output logic [OUT_W-1:0]   out_data
);

   localparam int ACC_W = DATA_W + COEF_W + pp_interp_pkg::pp_clog2(TAPS) + 1;
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

   if (PHASES < 2)        begin : g_chk_ph  $error("PHASES must be at least 2"); end
   if (TAPS < 1)          begin : g_chk_tp  $error("TAPS must be at least 1"); end
   if (FRAC_W >= ACC_W)   begin : g_chk_fr  $error("FRAC_W too large for accumulator"); end
   if (OUT_W + FRAC_W > ACC_W) begin : g_chk_ow  $error("OUT_W too large for accumulator"); end

   logic [PH_W-1:0]          ph_q;
   logic                     accept;
   logic [TAPS*DATA_W-1:0]   taps;
   logic [TAPS*COEF_W-1:0]   coefs;
   logic [OUT_W-1:0]         y;

   assign in_ready = (ph_q == '0);
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst)              ph_q <= '0;
      else if (accept)      ph_q <= PH_W'(1);
      else if (ph_q != '0)  ph_q <= (ph_q == LAST_PH) ? '0 : ph_q + PH_W'(1);
   end

   pp_delay_line #(.DATA_W(DATA_W), .DEPTH(TAPS)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .shift_en (accept),
      .din      (in_data),
      .taps_o   (taps)
   );

   pp_coef_mux #(
      .COEF_W(COEF_W), .PHASES(PHASES), .TAPS(TAPS), .PH_W(PH_W), .COEFS(COEFS)
   ) u_coef (
      .sel    (ph_q),
      .coef_o (coefs)
   );

   pp_mac_round_sat #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS),
      .FRAC_W(FRAC_W), .OUT_W(OUT_W), .ACC_W(ACC_W)
   ) u_mac (
      .taps_i  (taps),
      .coefs_i (coefs),
      .y_o     (y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_phase <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= accept || (ph_q != '0);
         out_phase <= ph_q;
         out_data  <= y;
      end
   end

endmodule

// File: rtl/pp_interp_checker.sv
module pp_interp_checker #(
   parameter int PHASES = 4,
   localparam int PH_W  = pp_interp_pkg::pp_clog2(PHASES)
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic            in_ready,
   input logic            out_valid,
   input logic [PH_W-1:0] out_phase
);

   localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

   // R3: an accepted sample opens a burst at phase 0
   a_r3_accept_opens_burst: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid && out_phase == '0);

   // R3: a phase-0 output only follows an accept on the previous edge
   a_r3_burst_has_origin: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_phase == '0 |-> $past(in_valid && in_ready));

   // R3: phases advance by one with no gap until the last
   a_r3_phase_advance: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_phase != LAST_PH |=> out_valid && out_phase == $past(out_phase) + PH_W'(1));

   // R2: no sample is taken while a burst is under way
   a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_phase != LAST_PH |-> !in_ready);

   // R7: idle or finishing the last phase means ready for a sample
   a_r7_idle_ready: assert property (@(posedge clk) disable iff (rst)
      !out_valid || out_phase == LAST_PH |-> in_ready);

endmodule

bind polyphase_interp4 pp_interp_checker #(.PHASES(PHASES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_phase (out_phase)
);

// File: tb/tb_polyphase_interp4.sv
module tb_polyphase_interp4;

   // Time unit taken as 1 ns: a 4 ns period gives 250 MHz.
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [15:0] in_data;
   logic        in_ready;
   logic        out_valid;
   logic [1:0]  out_phase;
   logic [15:0] out_data;

   always #2 clk = ~clk;

   polyphase_interp4 dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_phase(out_phase),
      .out_data(out_data)
   );

   // Prototype coefficients as written in the requirements, h[0]..h[7]
   int h [8] = '{8192, 16384, 24576, 32767, 24576, 16384, 8192, 16384};

   typedef struct { int ph; int val; bit sat; } exp_t;
   exp_t  exp_q [$];
   int    u [8];           // zero-stuffed stream history, u[0] newest
   int    model_ph;
   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   string cur_tag  = "R4";

   task automatic chk(input string req, input int act, input int expv);
      n_checks++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
      end
   endtask

   task automatic model_clear();
      for (int j = 0; j < 8; j++) u[j] = 0;
      exp_q.delete();
      model_ph = 0;
   endtask

   // Zero insertion followed by the direct eight-tap filter
   task automatic model_accept(input int x);
      for (int k = 0; k < 4; k++) begin
         longint s;
         exp_t e;
         for (int j = 7; j > 0; j--) u[j] = u[j-1];
         u[0] = (k == 0) ? x : 0;
         s = 0;
         for (int j = 0; j < 8; j++) s += longint'(h[j]) * longint'(u[j]);
         s = (s + 64'sd16384) >>> 15;
         e.ph  = k;
         e.sat = (s > 32767) || (s < -32768);
         e.val = (s > 32767) ? 32767 : (s < -32768) ? -32768 : int'(s);
         exp_q.push_back(e);
      end
   endtask

   task automatic check_outputs();
      chk("R2", int'(in_ready), (model_ph == 0) ? 1 : 0);
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk("R3", int'(out_valid), 1);
         chk("R3", int'(out_phase), e.ph);
         chk(e.sat ? "R6" : cur_tag, int'($signed(out_data)), e.val);
      end else begin
         chk("R7", int'(out_valid), 0);
      end
   endtask

   // One clock: check what the last edge produced, then drive the next edge
   task automatic cyc(input bit v, input int d);
      @(negedge clk);
      check_outputs();
      in_valid = v;
      in_data  = 16'(d);
      if (v && model_ph == 0) begin
         model_accept(int'($signed(16'(d))));
         model_ph = 1;
      end else if (model_ph != 0) begin
         model_ph = (model_ph + 1) % 4;
      end
   endtask

   // Offer a sample, then fill the busy cycles with ignored offers (R2)
   task automatic feed(input int d, input bit junk, input int gap);
      cyc(1'b1, d);
      for (int i = 0; i < 3; i++) cyc(junk, junk ? int'($urandom_range(0, 65535)) : 0);
      for (int i = 0; i < gap; i++) cyc(1'b0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      in_data  = '0;
      model_clear();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk("R1", int'(out_valid), 0);
      chk("R1", int'(in_ready), 1);
      chk("R1", int'($signed(out_data)), 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      rst = 1'b1;
      in_valid = 1'b0;
      in_data = '0;
      model_clear();
      do_reset();

      // R1, R4: impulse right after reset, then zeros flush the history
      cur_tag = "R1";
      feed(32767, 1'b0, 0);
      cur_tag = "R4";
      feed(0, 1'b0, 0);
      feed(-12000, 1'b1, 0);
      feed(5000, 1'b1, 0);
      feed(0, 1'b0, 2);

      // R5: exact half values round toward plus infinity
      cur_tag = "R5";
      feed(1, 1'b0, 0);
      feed(-1, 1'b0, 0);
      feed(2, 1'b0, 0);
      feed(-2, 1'b1, 0);
      feed(3, 1'b0, 0);
      feed(-3, 1'b0, 1);

      // R7: stalls keep history; next burst still uses last accepted sample
      cur_tag = "R7";
      feed(20000, 1'b0, 3);
      feed(-7000, 1'b1, 5);
      feed(11111, 1'b0, 1);

      // R2, R4: random data, random junk offers and gaps
      cur_tag = "R4";
      for (int i = 0; i < 60; i++) begin
         feed(int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)),
              int'($urandom_range(0, 2)));
      end

      // R6: full scale of both signs
      for (int i = 0; i < 4; i++) feed(32767, 1'b1, 0);
      for (int i = 0; i < 4; i++) feed(-32768, 1'b1, 0);
      for (int i = 0; i < 6; i++) feed((i % 2 == 0) ? 32767 : -32768, 1'b0, 0);
      feed(0, 1'b0, 1);

      // R1: reset in the middle of a burst, history restarts at zero
      cyc(1'b1, 30000);
      cyc(1'b0, 0);
      do_reset();
      cur_tag = "R1";
      feed(-32768, 1'b0, 0);
      cur_tag = "R4";
      feed(9999, 1'b1, 3);

      done = 1'b1;
      finish_run();
   end

endmodule